// File: doc/BRIEF.md
# Quadrature Table-Lookup FM Modulator

The block turns a stream of signed audio samples into a frequency-modulated carrier in quadrature form. Each accepted sample is scaled by a fixed sensitivity constant. The carrier step word is added to that scaled value, and the sum advances a phase accumulator that wraps freely. The top bits of the phase address two lookup tables, one holding a single cosine period and one holding a single sine period, and the two table outputs leave the block as an I/Q pair.

Samples enter through a valid/ready port and results leave through a valid/ready port. The pipeline has three register stages: scale, accumulate, table read. All three stages advance together whenever the output register is empty or the consumer is ready. When the consumer holds `out_ready` low while a result is waiting, the whole pipeline freezes, `in_ready` drops, and the waiting result stays unchanged on the output. Bubbles from gaps in `in_valid` pass through without touching the phase.

Top module: `fm_modulator`

## Requirements
- R1: Synchronous active-low reset clears the phase accumulator to 0 and empties the pipeline, so `out_valid` is 0 and `in_ready` is 1 right after reset. The first sample accepted after reset therefore produces phase = CARRIER_WORD + KF·sample.
- R2: On each accepted sample, the phase becomes phase + CARRIER_WORD + KF·sample modulo 2^32. The product is signed (KF is 12-bit signed, the sample is 16-bit signed) and is sign-extended to 32 bits.
- R3: Table entry k, for k in 0..1023, is 1024·sin(2πk/1024) or 1024·cos(2πk/1024) truncated toward zero. Every output therefore lies in −1024..1024.
- R4: `out_i` is the cosine entry and `out_q` is the sine entry. Both are addressed by bits 31:22 of the phase as it stands after that sample's update.
- R5: The phase changes only on a sample accepted with `in_valid`=1 and `in_ready`=1. Idle cycles leave it unchanged.
- R6: While `out_valid`=1 and `out_ready`=0, `out_i`, `out_q` and `out_valid` hold their values and `in_ready` is 0. Otherwise `in_ready` is 1.
- R7: With `out_ready` held at 1 and the pipeline empty, a sample accepted at a rising edge produces `out_valid`=1 after the third rising edge, counting the accepting edge as the first. Results leave in the order the samples arrived.
- R8: With all samples zero, the table address advances by CARRIER_WORD[31:22] (4 by default) on each output.
- R9: The phase wraps past 2^32 with no saturation, and the address continues modulo 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample taken this edge if in_valid |
| in_sample | input | 16 | Signed modulating sample |
| out_valid | output | 1 | I/Q pair present |
| out_ready | input | 1 | Consumer takes the pair this edge |
| out_i | output | 12 | Signed cosine output |
| out_q | output | 12 | Signed sine output |

## Verification
The bench covers every table address with a positive sample whose phase step is 5 entries, which is coprime with 1024. A table built with rounding instead of truncation, or with I and Q swapped, would then mismatch at some address. Full-scale negative and positive samples check the signed product. A design that zero-extended the product would drift upward at every negative input, and one that saturated the phase would stick near the top of the circle instead of wrapping. Random back-pressure with input gaps checks ordering and the idle phase: a pipeline that advanced on stall would drop or repeat pairs, and one that stepped on bubbles would shift every later address. The bench also checks the exact three-edge latency and confirms that a reset in mid-stream restarts the phase at zero.

// File: rtl/fm_mod_pkg.sv
package fm_mod_pkg;

  localparam real TWO_PI = 6.283185307179586476925;

  // One period of a sinusoid, scaled and truncated toward zero
  function automatic int tab_entry(input int k, input int npts, input int amp, input bit use_cos);
    real ang;
    real v;
    ang = TWO_PI * real'(k) / real'(npts);
    v   = use_cos ? $cos(ang) : $sin(ang);
    return $rtoi(real'(amp) * v);
  endfunction

endpackage

// File: rtl/fm_scale.sv
module fm_scale #(
  parameter int              SAMPLE_W     = 16,
  parameter int              KF_W         = 12,
  parameter int              KF           = 256,
  parameter int              PHASE_W      = 32,
  parameter logic [31:0]     CARRIER_WORD = 32'h0100_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic                       v_in,
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic                       v_out,
  output logic [PHASE_W-1:0]         incr
);
  localparam int PROD_W = SAMPLE_W + KF_W;
  localparam logic signed [KF_W-1:0]  KF_C = KF_W'(KF);
  localparam logic [PHASE_W-1:0]      W_C  = PHASE_W'(CARRIER_WORD);

  logic signed [PROD_W-1:0] prod;
  logic [PHASE_W-1:0]       prod_ext;

  assign prod     = $signed(PROD_W'(KF_C)) * $signed(PROD_W'(sample));
  assign prod_ext = {{(PHASE_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      incr  <= '0;
    end else if (adv) begin
      v_out <= v_in;
      if (v_in) incr <= W_C + prod_ext;
    end
  end

endmodule

// File: rtl/fm_phase_acc.sv
module fm_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               v_in,
  input  logic [PHASE_W-1:0] incr,
  output logic               v_out,
  output logic [PHASE_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_out <= 1'b0;
      phase <= '0;
    end else if (adv) begin
      v_out <= v_in;
      if (v_in) phase <= phase + incr;
    end
  end

  // R5: phase only moves when a valid step is taken
  a_r5_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(adv && v_in) |=> $stable(phase));

endmodule

// File: rtl/fm_quad_rom.sv
module fm_quad_rom #(
  parameter int ADDR_W  = 10,
  parameter int AMP_W   = 12,
  parameter int AMP     = 1024,
  parameter bit USE_COS = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [AMP_W-1:0] data
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic signed [AMP_W-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam int V = fm_mod_pkg::tab_entry(k, DEPTH, AMP, USE_COS);
    assign rom[k] = AMP_W'(V);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  data <= '0;
    else if (en) data <= rom[addr];
  end

  // R3: every entry within the amplitude bound
  a_r3_amp_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(data) <= AMP) && (int'(data) >= -AMP));

endmodule

// File: rtl/fm_modulator.sv
module fm_modulator #(
  parameter int          SAMPLE_W     = 16,
  parameter int          KF_W         = 12,
  parameter int          KF           = 256,
  parameter int          PHASE_W      = 32,
  parameter logic [31:0] CARRIER_WORD = 32'h0100_0000,
  parameter int          ADDR_W       = 10,
  parameter int          AMP          = 1024,
  parameter int          AMP_W        = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic signed [AMP_W-1:0]    out_i,
  output logic signed [AMP_W-1:0]    out_q
);
  logic               adv;
  logic               s1_v, s2_v, s3_v;
  logic [PHASE_W-1:0] incr, phase;
  logic [ADDR_W-1:0]  addr;
  logic signed [AMP_W-1:0] lane [2];
  int                 mag2;

  assign adv      = !s3_v || out_ready;
  assign in_ready = adv;
  assign addr     = phase[PHASE_W-1 -: ADDR_W];

  fm_scale #(
    .SAMPLE_W(SAMPLE_W), .KF_W(KF_W), .KF(KF),
    .PHASE_W(PHASE_W), .CARRIER_WORD(CARRIER_WORD)
  ) u_scale (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(in_valid),
    .sample(in_sample), .v_out(s1_v), .incr(incr)
  );

  fm_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .adv(adv), .v_in(s1_v),
    .incr(incr), .v_out(s2_v), .phase(phase)
  );

  // lane 0 = cosine (I), lane 1 = sine (Q)
  for (genvar g = 0; g < 2; g++) begin : g_lane
    fm_quad_rom #(
      .ADDR_W(ADDR_W), .AMP_W(AMP_W), .AMP(AMP), .USE_COS(g == 0)
    ) u_rom (
      .clk(clk), .rst_n(rst_n), .en(adv && s2_v),
      .addr(addr), .data(lane[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   s3_v <= 1'b0;
    else if (adv) s3_v <= s2_v;
  end

  assign out_valid = s3_v;
  assign out_i     = lane[0];
  assign out_q     = lane[1];

  assign mag2 = int'(out_i) * int'(out_i) + int'(out_q) * int'(out_q);

  // R6: a stalled result stays put
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  // R4: I and Q come from the same address of the cosine and sine tables
  a_r4_quad_mag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (mag2 <= AMP * AMP) && (mag2 >= (AMP - 2) * (AMP - 2)));

  // R7: a result only appears after the pipeline advanced
  a_r7_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(adv));

endmodule

// File: tb/sim_fm_modulator.sv
module sim_fm_modulator;
  localparam int          CLK_PERIOD = 10;
  localparam int          KF         = 256;
  localparam logic [31:0] CW         = 32'h0100_0000;
  localparam real         TWO_PI     = 6.283185307179586476925;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic in_ready, out_valid;
  logic signed [11:0] out_i, out_q;

  int checks = 0;
  int fails  = 0;
  logic [31:0] mph = '0;
  int exp_i[$];
  int exp_q[$];
  string exp_t[$];
  logic obs_ov, obs_ir;
  logic [15:0] lf = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_modulator u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_i(out_i), .out_q(out_q)
  );

  function automatic int ref_val(input int a, input bit c);
    real ang;
    ang = TWO_PI * real'(a) / 1024.0;
    return $rtoi(1024.0 * (c ? $cos(ang) : $sin(ang)));
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic signed [15:0] s, input logic ordy, input string tag);
    int p;
    int a;
    @(negedge clk);
    in_valid = v; in_sample = s; out_ready = ordy;
    #1;
    obs_ov = out_valid; obs_ir = in_ready;
    if (out_valid && out_ready) begin
      if (exp_i.size() == 0) chk(1'b0, "R7", "unexpected output", 1, 0);
      else begin
        int ei, eq;
        string t;
        ei = exp_i.pop_front(); eq = exp_q.pop_front(); t = exp_t.pop_front();
        chk(int'(out_i) == ei, t, "out_i", int'(out_i), ei);
        chk(int'(out_q) == eq, t, "out_q", int'(out_q), eq);
      end
    end
    if (in_valid && in_ready) begin
      p = KF * int'(s);
      mph = mph + CW + 32'(p);
      a = int'(mph[31:22]);
      exp_i.push_back(ref_val(a, 1'b1));
      exp_q.push_back(ref_val(a, 1'b0));
      exp_t.push_back(tag);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    mph = '0;
    exp_i.delete(); exp_q.delete(); exp_t.delete();
    rst_n = 1'b1;
  endtask

  task automatic drain(input string tag);
    for (int n = 0; n < 8; n++) step(1'b0, 16'sd0, 1'b1, tag);
    chk(exp_i.size() == 0, tag, "pending results after drain", exp_i.size(), 0);
  endtask

  initial begin
    logic ov1, ov2, ov3;
    logic signed [11:0] hi, hq;
    do_reset();
    #1;
    // R1: empty pipeline after reset
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);

    // R7: three-edge latency
    step(1'b1, 16'sd0, 1'b1, "R7");
    step(1'b0, 16'sd0, 1'b1, "R7"); ov1 = obs_ov;
    step(1'b0, 16'sd0, 1'b1, "R7"); ov2 = obs_ov;
    step(1'b0, 16'sd0, 1'b1, "R7"); ov3 = obs_ov;
    chk(ov1 == 1'b0, "R7", "valid after edge 1", int'(ov1), 0);
    chk(ov2 == 1'b0, "R7", "valid after edge 2", int'(ov2), 0);
    chk(ov3 == 1'b1, "R7", "valid after edge 3", int'(ov3), 1);
    drain("R7");

    // R8: zero input gives a constant carrier step
    for (int n = 0; n < 260; n++) step(1'b1, 16'sd0, 1'b1, "R8");
    drain("R8");

    // R3 / R4: step of 5 entries visits all 1024 addresses
    for (int n = 0; n < 1030; n++) step(1'b1, 16'sd16384, 1'b1, "R3");
    drain("R3");

    // R2 / R9: full-scale signed samples, wrapping phase
    for (int n = 0; n < 300; n++) step(1'b1, 16'sh7FFF, 1'b1, "R9");
    for (int n = 0; n < 300; n++) step(1'b1, 16'sh8000, 1'b1, "R2");
    for (int n = 0; n < 200; n++) step(1'b1, (n % 2) ? -16'sd12345 : 16'sd777, 1'b1, "R2");
    drain("R2");

    // R6: explicit stall
    step(1'b1, 16'sd3000, 1'b0, "R6");
    for (int n = 0; n < 4; n++) step(1'b0, 16'sd0, 1'b0, "R6");
    hi = out_i; hq = out_q;
    chk(obs_ov == 1'b1, "R6", "valid while stalled", int'(obs_ov), 1);
    for (int n = 0; n < 5; n++) begin
      step(1'b1, 16'sd100, 1'b0, "R6");
      chk(obs_ir == 1'b0, "R6", "in_ready while stalled", int'(obs_ir), 0);
      chk(out_i == hi && out_q == hq, "R6", "held I", int'(out_i), int'(hi));
    end
    drain("R6");

    // R5 / R6: random gaps and back-pressure
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] & lf[3], $signed(lf ^ 16'h5A5A), lf[2] | lf[5], "R5");
    end
    drain("R5");

    // R1: mid-stream reset restarts the phase at zero
    for (int n = 0; n < 5; n++) step(1'b1, 16'sd999, 1'b0, "R1");
    do_reset();
    step(1'b1, 16'sd0, 1'b1, "R1");
    drain("R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule